// File: doc/BRIEF.md
# Prescaled Period-Match Timer

This block is a free-running or single-shot interval timer for a chip-internal clock domain. A narrow prescale counter divides the system clock down to a tick. Each tick advances a wide main counter, which is compared against a programmable match value. When the main counter reaches that value, the block issues three single-cycle pulses at the same time: an interrupt request, a DMA trigger, and a match strobe for a downstream waveform shaper. The current count is also visible.

The prescale counter climbs from zero to its programmed limit. On the cycle after it holds that limit, it issues one tick and restarts at zero, so the divide ratio is the limit plus one. The main counter behaves the same way on the tick time base: in continuous mode it reaches the match value and goes back to zero on the following tick. In single-shot mode the main counter parks at the match value after the first match and stays silent until it is cleared.

Four controls set the activity:
- Dropping the enable clears both counters and holds them at zero.
- The hold input freezes both counters, and any tick not yet consumed, without clearing them.
- A synchronous clear zeroes both counters, and it takes priority over hold.
- The only time base is the block's own clock.

Top module: `pmt_timer`

## Requirements
- R1: After the asynchronous reset is released, count reads 0 and irq, dma_evt and match are all 0.
- R2: While running, the prescale counter wraps so that count advances exactly once every presc_lim+1 clock cycles, for any presc_lim from 0 to 15.
- R3: In continuous mode (one_shot=0), count steps 0,1,...,match_val on successive ticks and returns to 0 on the tick after it equals match_val.
- R4: irq, dma_evt and match are identical single-cycle pulses, high in exactly the cycle in which count first shows match_val.
- R5: With match_val=0, count stays 0 and a pulse occurs on every tick, i.e. every presc_lim+1 cycles.
- R6: In single-shot mode (one_shot=1), after the first match count stays at match_val and no further pulse occurs until clr is applied, after which the timer runs and matches again.
- R7: While hold=1 (with en=1, clr=0), count does not change and no pulse occurs; after hold is released, counting resumes from where it stopped, with no tick gained or lost.
- R8: While en=0, count is 0 from the next cycle on and no pulse occurs, even with match_val=0.
- R9: clr=1 sets count to 0 on the next clock edge, also while hold=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the only time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer enable; low clears and holds at zero |
| hold | input | 1 | Freeze both counters without clearing |
| clr | input | 1 | Synchronous clear of both counters |
| one_shot | input | 1 | 1 = stop after first match, 0 = continuous |
| presc_lim | input | 4 | Prescale limit; divide ratio is presc_lim+1 |
| match_val | input | 32 | Main counter match value |
| count | output | 32 | Current main counter value |
| irq | output | 1 | Interrupt request pulse on match |
| dma_evt | output | 1 | DMA trigger pulse on match |
| match | output | 1 | Match strobe for output shaping |

## Verification
The assertions that relate a pulse to the match value assume that match_val and presc_lim stay steady while the timer runs. They compare the count against the value the limits had one cycle earlier, and a limit moved below the current count would only be caught at the counter's natural wrap. The bench therefore changes limits only together with a clear. It then holds them fixed for the whole scenario, and it changes hold, clr and en only at falling clock edges.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    // activity state shared by the prescaler and the main counter
    typedef enum logic [1:0] {
        CTL_CLEAR  = 2'd0,
        CTL_FREEZE = 2'd1,
        CTL_RUN    = 2'd2
    } ctl_e;

endpackage

// File: rtl/pmt_ctl.sv
module pmt_ctl
    import pmt_pkg::*;
(
    input  logic en,
    input  logic hold,
    input  logic clr,
    input  logic done,
    output ctl_e ctl
);

    always_comb begin
        if (clr || !en) begin
            ctl = CTL_CLEAR;
        end else if (hold || done) begin
            ctl = CTL_FREEZE;
        end else begin
            ctl = CTL_RUN;
        end
    end

endmodule

// File: rtl/pmt_prescaler.sv
module pmt_prescaler
    import pmt_pkg::*;
#(
    parameter int PSC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_e             ctl,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             tick;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ctl)
            CTL_CLEAR: begin
                st_d = '0;
            end
            CTL_FREEZE: begin
                st_d = st_q;    // an unconsumed tick is kept pending
            end
            default: begin
                if (st_q.psc == limit) begin
                    st_d.psc  = '0;
                    st_d.tick = 1'b1;
                end else begin
                    st_d.psc  = st_q.psc + 1'b1;
                    st_d.tick = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    AST_PSC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && st_q.psc == limit) |=> (st_q.psc == '0 && st_q.tick)); // R2

    AST_PSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_FREEZE) |=> ($stable(st_q.psc) && $stable(st_q.tick))); // R7

    AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_CLEAR) |=> (st_q.psc == '0 && !st_q.tick)); // R8

endmodule

// File: rtl/pmt_counter.sv
module pmt_counter
    import pmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_e             ctl,
    input  logic             tick,
    input  logic             one_shot,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hit;
        logic             done;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt = (st_q.cnt == limit) ? '0 : st_q.cnt + 1'b1;
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        unique case (ctl)
            CTL_CLEAR: begin
                st_d = '0;
            end
            CTL_FREEZE: begin
                st_d.hit = 1'b0;
            end
            default: begin
                if (tick) begin
                    st_d.cnt = nxt;
                    if (nxt == limit) begin
                        st_d.hit  = 1'b1;
                        st_d.done = one_shot;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign hit  = st_q.hit;
    assign done = st_q.done;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && tick && st_q.cnt != limit) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R3

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_RUN && tick && st_q.cnt == limit) |=> (st_q.cnt == '0)); // R3

    AST_HIT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hit |-> (st_q.cnt == $past(limit))); // R4

    AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hit |-> $past(tick && ctl == CTL_RUN)); // R2

    AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && ctl != CTL_CLEAR) |=> (!st_q.hit && $stable(st_q.cnt))); // R6

    AST_FREEZE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_FREEZE) |=> ($stable(st_q.cnt) && !st_q.hit)); // R7

endmodule

// File: rtl/pmt_timer.sv
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int PSC_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hold,
    input  logic             clr,
    input  logic             one_shot,
    input  logic [PSC_W-1:0] presc_lim,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             dma_evt,
    output logic             match
);

    ctl_e ctl;
    logic tick;
    logic hit;
    logic done;

    pmt_ctl i_ctl (
        .en   (en),
        .hold (hold),
        .clr  (clr),
        .done (done),
        .ctl  (ctl)
    );

    pmt_prescaler #(.PSC_W(PSC_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .limit (presc_lim),
        .tick  (tick)
    );

    pmt_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .tick     (tick),
        .one_shot (one_shot),
        .limit    (match_val),
        .cnt      (count),
        .hit      (hit),
        .done     (done)
    );

    assign irq     = hit;
    assign dma_evt = hit;
    assign match   = hit;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !irq)); // R9

    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == '0 && !irq)); // R8

    AST_PULSES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq == dma_evt) && (irq == match)); // R4

endmodule

// File: tb/test_pmt_timer.sv
`timescale 1ns/1ps
module test_pmt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        hold = 1'b0;
    logic        clr = 1'b0;
    logic        one_shot = 1'b0;
    logic [3:0]  presc_lim = '0;
    logic [31:0] match_val = '0;
    logic [31:0] count;
    logic        irq;
    logic        dma_evt;
    logic        match;

    int n_chk  = 0;
    int n_fail = 0;
    int n_cyc  = 0;

    always #4 clk = ~clk;   // 125 MHz

    pmt_timer i_pmt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hold      (hold),
        .clr       (clr),
        .one_shot  (one_shot),
        .presc_lim (presc_lim),
        .match_val (match_val),
        .count     (count),
        .irq       (irq),
        .dma_evt   (dma_evt),
        .match     (match)
    );

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", n_cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart(input int lim, input int mv, input logic os);
        @(negedge clk);
        clr = 1'b1; en = 1'b1; hold = 1'b0;
        one_shot = os; presc_lim = 4'(lim); match_val = 32'(mv);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic wait_change(input int limit, output int cyc);
        logic [31:0] prev;
        prev = count;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (count == prev && cyc < limit);
    endtask

    task automatic wait_irq(input int limit, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!irq && cyc < limit);
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dma_evt", dma_evt, 0);
        chk("R1 match", match, 0);
    endtask

    task automatic t_prescale(input int lim);
        int c;
        restart(lim, 100000, 1'b0);
        wait_change(40, c);
        for (int i = 0; i < 3; i++) begin
            wait_change(40, c);
            chk($sformatf("R2 spacing lim=%0d", lim), c, lim + 1);
        end
    endtask

    task automatic t_continuous();
        int c;
        int ex;
        restart(1, 3, 1'b0);
        for (int i = 0; i < 7; i++) begin
            wait_change(20, c);
            ex = (i + 1) % 4;
            chk("R3 sequence", count, ex);
            chk("R4 irq at match", irq, (ex == 3) ? 1 : 0);
            chk("R4 dma_evt agrees", dma_evt, irq);
            chk("R4 match agrees", match, irq);
            if (ex == 3) begin
                @(negedge clk);
                chk("R4 single cycle", irq, 0);
                chk("R3 holds before wrap", count, 3);
            end
        end
    endtask

    task automatic t_zero();
        int c;
        restart(2, 0, 1'b0);
        wait_irq(20, c);
        chk("R5 first pulse", irq, 1);
        for (int i = 0; i < 3; i++) begin
            wait_irq(20, c);
            chk("R5 pulse spacing", c, 3);
            chk("R5 count stays 0", count, 0);
        end
    endtask

    task automatic t_oneshot();
        int c;
        int seen;
        restart(0, 2, 1'b1);
        wait_irq(20, c);
        chk("R6 first match", irq, 1);
        chk("R6 count at match", count, 2);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) seen++;
        end
        chk("R6 no further pulse", seen, 0);
        chk("R6 parked at match", count, 2);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R6 clear rearms count", count, 0);
        wait_irq(20, c);
        chk("R6 matches again", irq, 1);
    endtask

    task automatic t_hold();
        int c;
        logic [31:0] v;
        restart(2, 100000, 1'b0);
        wait_change(20, c);
        hold = 1'b1;
        v = count;
        c = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (count != v || irq) c++;
        end
        chk("R7 frozen", c, 0);
        hold = 1'b0;
        wait_change(20, c);
        chk("R7 resume spacing", c, 3);
        chk("R7 resume value", count, v + 1);
    endtask

    task automatic t_clr_prio();
        restart(0, 100000, 1'b0);
        repeat (10) @(negedge clk);
        chk("R9 running before clear", (count > 0) ? 1 : 0, 1);
        hold = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        chk("R9 clear over hold", count, 0);
        clr = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 stays 0 under hold", count, 0);
        hold = 1'b0;
    endtask

    task automatic t_disable();
        int seen;
        restart(0, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R8 pulses while enabled", irq, 1);
        en = 1'b0;
        @(negedge clk);
        chk("R8 count cleared", count, 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq || count != 0) seen++;
        end
        chk("R8 quiet while off", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale(0);
        t_prescale(3);
        t_prescale(15);
        t_continuous();
        t_zero();
        t_oneshot();
        t_hold();
        t_clr_prio();
        t_disable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule